// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Sequencer

This block sits on the controller side of a double-data-rate SDRAM. It owns the clock-enable pin and, while a power transition is in progress, the command bus. It takes the device into and out of three low-power conditions: power-down with every bank closed, power-down with a bank still open, and self-refresh. The kind of power-down is chosen from the bank status at the moment of entry. Self-refresh is entered by lowering clock-enable on the same edge that carries an auto-refresh command.

Requests arrive as levels. A power-down request takes the device down on the next edge. A self-refresh request is remembered until the bank status reports every bank closed. A wake request raises clock-enable again. After any wake-up the block holds a quiet window of NOP cycles before the rest of the controller may issue commands again. After a self-refresh wake-up it also withholds permission to read until a long delay-locked-loop settling time has passed from the edge on which clock-enable rose.

A self-refresh request that arrives during power-down cannot be carried out without an illegal clock-enable and command pair. The block drops that request and raises an error pulse instead.

Top module: `cke_power_seq`

## Requirements
- R1: After synchronous reset: `cke_o`=1, `cmd_o`=NOP (code 1), `mode_o`=ACTIVE (code 0), `cmd_allow_o`=1, `rd_allow_o`=1, `err_o`=0.
- R2: In ACTIVE with `pd_req_i`=1, no self-refresh pending and `bank_open_i`=0, the next edge drives `cke_o` low with NOP (1), sets `mode_o` to PD_PRECHARGE (code 1) and drops `cmd_allow_o`.
- R3: The same request with `bank_open_i`=1 enters PD_ACTIVE (code 2), again with `cke_o` falling and NOP.
- R4: While powered down, every edge after the entry edge keeps `cke_o` low with DESELECT (code 0). Power-down requests and bank-status changes have no effect until a wake request.
- R5: A self-refresh request with `bank_open_i`=0 in ACTIVE drives `cke_o` low together with AUTO-REFRESH (code 2) on the next edge and enters SELF_REFRESH (code 3). It takes priority over a simultaneous power-down request. AUTO-REFRESH never appears except on an edge where `cke_o` falls.
- R6: A self-refresh request made while `bank_open_i`=1 is held pending with `cke_o` high. It is carried out on the first edge at which banks report idle in ACTIVE.
- R7: A wake request in any powered-down mode raises `cke_o` with NOP on the next edge and enters EXIT (code 4). EXIT keeps `cke_o` high with NOP for `EXIT_CYC` edges, counted from the rising edge, before `mode_o` returns to ACTIVE and `cmd_allow_o` is set.
- R8: After a self-refresh exit, `rd_allow_o` stays 0 until `RD_HOLD` edges after the edge on which `cke_o` rose. After a power-down exit, `rd_allow_o` rises together with `cmd_allow_o`.
- R9: A self-refresh request during either power-down mode pulses `err_o` on the next edge and is discarded, so that after wake-up no self-refresh entry follows.
- R10: In ACTIVE with no request, a wake request has no effect: `cke_o` stays high with NOP and `mode_o` stays ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_open_i | input | 1 | 1 when at least one bank is open, 0 when all are idle |
| pd_req_i | input | 1 | Power-down request (level) |
| sr_req_i | input | 1 | Self-refresh request |
| wake_req_i | input | 1 | Wake request from power-down or self-refresh |
| cke_o | output | 1 | Registered clock-enable level |
| cmd_o | output | 3 | Command code: 0 DESELECT, 1 NOP, 2 AUTO-REFRESH |
| mode_o | output | 3 | Power mode: 0 ACTIVE, 1 PD_PRECHARGE, 2 PD_ACTIVE, 3 SELF_REFRESH, 4 EXIT |
| cmd_allow_o | output | 1 | Other commands may be issued |
| rd_allow_o | output | 1 | Read commands may be issued |
| err_o | output | 1 | One-cycle pulse for a request that would need an illegal pair |

## Verification
The assertions assume the rest of the controller does not open a bank while the device is powered down. They also assume requests are levels sampled on the clock, so a wake request only matters in a powered-down mode. The bench drives every input on the falling clock edge and changes the bank status only in ACTIVE, or in power-down where it must be ignored, and then sets it back before wake-up. Self-refresh requests are given both with banks idle and with a bank open, and once during power-down to reach the error path.

// File: rtl/ckeseq_pkg.sv
package ckeseq_pkg;

    typedef enum logic [2:0] {
        MODE_ACTIVE = 3'd0,
        MODE_PD_PRE = 3'd1,
        MODE_PD_ACT = 3'd2,
        MODE_SREF   = 3'd3,
        MODE_EXIT   = 3'd4
    } pmode_e;

    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_AREF  = 3'd2
    } cmd_e;

    typedef struct packed {
        logic cke;
        cmd_e cmd;
    } bus_t;

    function automatic logic is_low_power(pmode_e m);
        return (m == MODE_PD_PRE) || (m == MODE_PD_ACT) || (m == MODE_SREF);
    endfunction

    function automatic int cnt_width(int unsigned load_val);
        return (load_val < 2) ? 1 : $clog2(load_val + 1);
    endfunction

endpackage

// File: rtl/cke_seq_timer.sv
module cke_seq_timer
    import ckeseq_pkg::*;
#(
    parameter int unsigned LOAD_VAL = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic zero_o
);
    localparam int W = cnt_width(LOAD_VAL);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= W'(LOAD_VAL);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    // R8: once expired, the window stays expired until reloaded
    p_hold_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/cke_seq_fsm.sv
module cke_seq_fsm
    import ckeseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bank_open_i,
    input  logic   pd_req_i,
    input  logic   sr_req_i,
    input  logic   wake_req_i,
    input  logic   exit_done_i,
    output bus_t   bus_o,
    output pmode_e mode_o,
    output logic   err_o,
    output logic   exit_load_o,
    output logic   hold_load_o
);
    pmode_e mode_q, mode_d;
    bus_t   bus_q, bus_d;
    logic   pend_q, pend_d;
    logic   err_q, err_d;
    logic   sr_want;

    assign sr_want = pend_q || sr_req_i;

    always_comb begin
        mode_d      = mode_q;
        bus_d.cke   = 1'b1;
        bus_d.cmd   = CMD_NOP;
        pend_d      = pend_q;
        err_d       = 1'b0;
        exit_load_o = 1'b0;
        hold_load_o = 1'b0;
        unique case (mode_q)
            MODE_ACTIVE: begin
                if (sr_want && !bank_open_i) begin
                    mode_d    = MODE_SREF;
                    bus_d.cke = 1'b0;
                    bus_d.cmd = CMD_AREF;
                    pend_d    = 1'b0;
                end else begin
                    pend_d = sr_want;
                    if (pd_req_i) begin
                        mode_d    = bank_open_i ? MODE_PD_ACT : MODE_PD_PRE;
                        bus_d.cke = 1'b0;
                    end
                end
            end
            MODE_PD_PRE, MODE_PD_ACT: begin
                err_d = sr_req_i;
                if (wake_req_i) begin
                    mode_d      = MODE_EXIT;
                    exit_load_o = 1'b1;
                end else begin
                    bus_d.cke = 1'b0;
                    bus_d.cmd = CMD_DESEL;
                end
            end
            MODE_SREF: begin
                if (wake_req_i) begin
                    mode_d      = MODE_EXIT;
                    exit_load_o = 1'b1;
                    hold_load_o = 1'b1;
                end else begin
                    bus_d.cke = 1'b0;
                    bus_d.cmd = CMD_DESEL;
                end
            end
            MODE_EXIT: begin
                pend_d = sr_want;
                if (exit_done_i) begin
                    mode_d = MODE_ACTIVE;
                end
            end
            default: begin
                mode_d = MODE_ACTIVE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_ACTIVE;
            bus_q.cke <= 1'b1;
            bus_q.cmd <= CMD_NOP;
            pend_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            mode_q <= mode_d;
            bus_q  <= bus_d;
            pend_q <= pend_d;
            err_q  <= err_d;
        end
    end

    assign bus_o  = bus_q;
    assign mode_o = mode_q;
    assign err_o  = err_q;

    // R4: clock-enable low on two edges in a row carries only DESELECT
    p_low_desel_r4: assert property (@(posedge clk) disable iff (rst)
        (!bus_q.cke && !$past(bus_q.cke)) |-> (bus_q.cmd == CMD_DESEL));

    // R5: auto-refresh only on the falling clock-enable edge
    p_aref_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_q.cmd == CMD_AREF) |-> (!bus_q.cke && $past(bus_q.cke)));

    // R6: self-refresh is only entered from idle banks
    p_sref_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SREF && $past(mode_q) != MODE_SREF) |-> !$past(bank_open_i));

    // R7: clock-enable rises with NOP, and the exit window stays quiet
    p_rise_nop_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_q.cke) |-> (bus_q.cmd == CMD_NOP && mode_q == MODE_EXIT));

    p_exit_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_EXIT) |-> (bus_q.cke && bus_q.cmd == CMD_NOP));

    // R2: clock-enable is low exactly in the low-power modes
    p_cke_mode_r2: assert property (@(posedge clk) disable iff (rst)
        bus_q.cke == !is_low_power(mode_q));

    // R9: errors are only reported on leaving or staying in power-down
    p_err_src_r9: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (mode_q == MODE_PD_PRE || mode_q == MODE_PD_ACT || mode_q == MODE_EXIT));

endmodule

// File: rtl/cke_power_seq.sv
module cke_power_seq
    import ckeseq_pkg::*;
#(
    parameter int unsigned EXIT_CYC = 10,
    parameter int unsigned RD_HOLD  = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bank_open_i,
    input  logic       pd_req_i,
    input  logic       sr_req_i,
    input  logic       wake_req_i,
    output logic       cke_o,
    output logic [2:0] cmd_o,
    output logic [2:0] mode_o,
    output logic       cmd_allow_o,
    output logic       rd_allow_o,
    output logic       err_o
);
    localparam int unsigned EXIT_LOAD = (EXIT_CYC > 0) ? EXIT_CYC - 1 : 0;

    bus_t   bus;
    pmode_e mode;
    logic   exit_load, hold_load;
    logic   exit_done, hold_done;

    cke_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .bank_open_i (bank_open_i),
        .pd_req_i    (pd_req_i),
        .sr_req_i    (sr_req_i),
        .wake_req_i  (wake_req_i),
        .exit_done_i (exit_done),
        .bus_o       (bus),
        .mode_o      (mode),
        .err_o       (err_o),
        .exit_load_o (exit_load),
        .hold_load_o (hold_load)
    );

    cke_seq_timer #(.LOAD_VAL(EXIT_LOAD)) u_exit_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (exit_load),
        .zero_o (exit_done)
    );

    cke_seq_timer #(.LOAD_VAL(RD_HOLD)) u_hold_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (hold_load),
        .zero_o (hold_done)
    );

    assign cke_o       = bus.cke;
    assign cmd_o       = bus.cmd;
    assign mode_o      = mode;
    assign cmd_allow_o = (mode == MODE_ACTIVE);
    assign rd_allow_o  = (mode == MODE_ACTIVE) && hold_done;

endmodule

// File: tb/cke_power_seq_tb.sv
module cke_power_seq_tb;
    localparam int EXIT_CYC = 10;
    localparam int RD_HOLD  = 200;

    logic clk = 1'b0;
    logic rst, bank_open, pd_req, sr_req, wake_req;
    logic cke, cmd_allow, rd_allow, err;
    logic [2:0] cmd, mode;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cke_power_seq #(.EXIT_CYC(EXIT_CYC), .RD_HOLD(RD_HOLD)) u_dut (
        .clk(clk), .rst(rst), .bank_open_i(bank_open), .pd_req_i(pd_req),
        .sr_req_i(sr_req), .wake_req_i(wake_req), .cke_o(cke), .cmd_o(cmd),
        .mode_o(mode), .cmd_allow_o(cmd_allow), .rd_allow_o(rd_allow), .err_o(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wake from a low-power mode and run through the exit window (R7)
    task automatic do_wake();
        int bad = 0;
        wake_req = 1'b1;
        step(1);
        chk("R7 cke rises", cke, 1);
        chk("R7 nop on rise", cmd, 1);
        chk("R7 exit mode", mode, 4);
        wake_req = 1'b0;
        for (int i = 1; i < EXIT_CYC; i++) begin
            step(1);
            if (mode != 4 || cmd != 1 || cmd_allow != 0) bad++;
        end
        chk("R7 window held", bad, 0);
        step(1);
        chk("R7 back to active", mode, 0);
        chk("R7 cmd allowed", cmd_allow, 1);
    endtask

    task automatic t_reset();
        chk("R1 cke", cke, 1);
        chk("R1 cmd", cmd, 1);
        chk("R1 mode", mode, 0);
        chk("R1 cmd_allow", cmd_allow, 1);
        chk("R1 rd_allow", rd_allow, 1);
        chk("R1 err", err, 0);
    endtask

    task automatic t_idle_wake();
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        chk("R10 cke stays high", cke, 1);
        chk("R10 mode stays", mode, 0);
        chk("R10 nop", cmd, 1);
    endtask

    task automatic t_pd_pre();
        bank_open = 1'b0;
        pd_req = 1'b1;
        step(1);
        chk("R2 cke low", cke, 0);
        chk("R2 nop on entry", cmd, 1);
        chk("R2 mode", mode, 1);
        chk("R2 cmd_allow", cmd_allow, 0);
        pd_req = 1'b0;
        step(1);
        chk("R4 deselect", cmd, 0);
        bank_open = 1'b1;
        pd_req = 1'b1;
        step(3);
        chk("R4 mode kept", mode, 1);
        chk("R4 cke kept", cke, 0);
        chk("R4 deselect kept", cmd, 0);
        bank_open = 1'b0;
        pd_req = 1'b0;
        step(1);
        do_wake();
        chk("R8 read after pd exit", rd_allow, 1);
    endtask

    task automatic t_pd_act();
        bank_open = 1'b1;
        pd_req = 1'b1;
        step(1);
        pd_req = 1'b0;
        chk("R3 mode", mode, 2);
        chk("R3 cke low", cke, 0);
        chk("R3 nop on entry", cmd, 1);
        step(2);
        chk("R4 deselect active pd", cmd, 0);
        do_wake();
        bank_open = 1'b0;
    endtask

    task automatic t_sref();
        bank_open = 1'b0;
        sr_req = 1'b1;
        pd_req = 1'b1;
        step(1);
        sr_req = 1'b0;
        pd_req = 1'b0;
        chk("R5 cke low", cke, 0);
        chk("R5 auto-refresh", cmd, 2);
        chk("R5 mode sref", mode, 3);
        step(2);
        chk("R4 deselect in sref", cmd, 0);
        do_wake();
        chk("R8 read held at window end", rd_allow, 0);
        step(RD_HOLD - EXIT_CYC - 1);
        chk("R8 read held last cycle", rd_allow, 0);
        step(1);
        chk("R8 read released", rd_allow, 1);
    endtask

    task automatic t_sr_pending();
        bank_open = 1'b1;
        sr_req = 1'b1;
        step(1);
        sr_req = 1'b0;
        step(2);
        chk("R6 still active", mode, 0);
        chk("R6 cke high", cke, 1);
        bank_open = 1'b0;
        step(1);
        chk("R6 entered sref", mode, 3);
        chk("R6 auto-refresh", cmd, 2);
        do_wake();
        step(RD_HOLD);
        chk("R8 read after pending sref", rd_allow, 1);
    endtask

    task automatic t_err();
        bank_open = 1'b0;
        pd_req = 1'b1;
        step(1);
        pd_req = 1'b0;
        sr_req = 1'b1;
        step(1);
        sr_req = 1'b0;
        chk("R9 err pulse", err, 1);
        chk("R9 still pd", mode, 1);
        step(1);
        chk("R9 err clears", err, 0);
        do_wake();
        step(3);
        chk("R9 request dropped", mode, 0);
        chk("R9 cke high", cke, 1);
    endtask

    initial begin
        rst = 1'b1;
        bank_open = 1'b0;
        pd_req = 1'b0;
        sr_req = 1'b0;
        wake_req = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_idle_wake();
        t_pd_pre();
        t_pd_act();
        t_sref();
        t_sr_pending();
        t_err();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule